// File: doc/BRIEF.md
# Two-Channel Bus Address Break Comparator

This debug block watches every cycle of a processor bus and raises a break request when an access matches a condition that software has programmed. It has two channels built the same way. Each channel holds a 24-bit break address and an 8-bit control byte. The control byte selects four things: how many low address bits are ignored, which kind of access counts, whether accesses made by the secondary transfer controller also count, and whether a match raises the interrupt.

When a channel matches, it sets a sticky match flag. Software cannot set this flag. It is cleared by a two-step sequence. First, a read of the control byte must return the flag as 1. Then a write of 0 to the flag bit clears it. The interrupt output is the OR of both channels' flags, each gated by its enable bit. It stays high until software clears the flags.

All registers sit on a byte-wide register port:

| Offset | Register |
|---|---|
| 0x0 to 0x2 | Break address of channel 0, least significant byte first |
| 0x4 to 0x6 | Break address of channel 1, least significant byte first |
| 0x8 | Control byte of channel 0 |
| 0x9 | Control byte of channel 1 |

Any other offset reads as 0.

Top module: `addr_break_unit`

## Requirements
- R1: After reset, every register byte reads 0 and `brk_irq` is 0.
- R2: Break address bytes are written and read back at offsets 0x0–0x2 (channel 0) and 0x4–0x6 (channel 1), least significant byte first. Unmapped offsets read 0.
- R3: Control byte layout, from bit 7 down to bit 0:
  - bit 7: match flag
  - bit 6: master select
  - bits 5:3: mask code
  - bits 2:1: cycle select
  - bit 0: interrupt enable

  Bits 6:0 are written and read back as written. Writing 1 to bit 7 never sets the flag.
- R4: The mask code sets how many low address bits the comparison ignores. Codes 0–4 ignore 0–4 bits. Codes 5, 6 and 7 ignore 8, 12 and 16 bits. All other address bits must be equal for a match.
- R5: `bus_kind` encodes 00 fetch, 01 data read, 10 data write, and 11 no access; 11 never matches. The cycle select encodes 00 fetch only, 01 read only, 10 write only, and 11 read or write.
- R6: With master select 0, only accesses with `bus_dtc` = 0 (CPU) can match. With master select 1, accesses by either master can match.
- R7: The match flag becomes 1 at the clock edge that samples a matching access with `bus_valid` high. It stays 1 with no further matches. An access with `bus_valid` low never matches.
- R8: Writing 0 to bit 7 clears the flag only if an earlier read of that control byte returned the flag as 1. Without that read, the write leaves the flag at 1.
- R9: The clear permission is disarmed by the next write to that control byte, even a write that does not clear the flag.
- R10: `brk_irq` is 1 exactly when some channel has both its flag and its enable bit at 1.
- R11: If a match and a valid clear land in the same cycle, the flag stays 1.
- R12: The two channels act independently. A match on one channel does not change the other channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the clear permission) |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from offset) |
| bus_valid | input | 1 | One-cycle strobe marking a bus access |
| bus_addr | input | 24 | Bus access address |
| bus_kind | input | 2 | Access type: 00 fetch, 01 read, 10 write, 11 none |
| bus_dtc | input | 1 | 1 when the transfer controller owns the bus, 0 for CPU |
| brk_irq | output | 1 | Break interrupt request |

## Verification
The mask comparator is swept over all eight codes. For each code, the bench tries the exact break address and then flips each of the 24 address bits one at a time. This shows precisely where the boundary between ignored and compared bits lies.

A second sweep covers every pairing of cycle select, access type, master select and bus master. It separates the single-type filters from the read-or-write filter and shows that the idle type is rejected.

Directed sequences then cover the remaining flag behaviour:
- a write of 0 with no prior read
- a disarming write that sets bit 7
- a match landing in the same cycle as a valid clear
- a match with the interrupt enable off
- a match on the second channel, showing the first is untouched

// File: rtl/abrk_pkg.sv
package abrk_pkg;

    localparam int NUM_CH      = 2;
    localparam int REG_AW      = 4;
    localparam int ADDR_STRIDE = 4;
    localparam logic [REG_AW-1:0] CTRL_BASE = 4'h8;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_IDLE  = 2'b11
    } bus_kind_e;

    typedef enum logic [1:0] {
        SEL_FETCH = 2'b00,
        SEL_READ  = 2'b01,
        SEL_WRITE = 2'b10,
        SEL_DATA  = 2'b11
    } cyc_sel_e;

    // Bit order is software visible: flag at bit 7, enable at bit 0.
    typedef struct packed {
        logic       hit_flag;
        logic       any_master;
        logic [2:0] mask_code;
        cyc_sel_e   cyc_sel;
        logic       irq_en;
    } brk_ctrl_t;

    // Number of low address bits that do not take part in the compare.
    function automatic int ignored_bits(input logic [2:0] code);
        int n;
        case (code)
            3'd5:    n = 8;
            3'd6:    n = 12;
            3'd7:    n = 16;
            default: n = int'(code);
        endcase
        return n;
    endfunction

    function automatic logic kind_accepts(input cyc_sel_e sel, input bus_kind_e kind);
        logic ok;
        case (sel)
            SEL_FETCH: ok = (kind == KIND_FETCH);
            SEL_READ:  ok = (kind == KIND_READ);
            SEL_WRITE: ok = (kind == KIND_WRITE);
            default:   ok = (kind == KIND_READ) || (kind == KIND_WRITE);
        endcase
        return ok;
    endfunction

    function automatic logic master_accepts(input logic any_master, input logic from_dtc);
        return !from_dtc || any_master;
    endfunction

endpackage

// File: rtl/abrk_match.sv
module abrk_match
    import abrk_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              strobe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  bus_kind_e         kind,
    input  logic              from_dtc,
    input  logic [ADDR_W-1:0] brk_addr,
    input  logic [2:0]        mask_code,
    input  cyc_sel_e          cyc_sel,
    input  logic              any_master,
    output logic              hit
);

    logic [ADDR_W-1:0] care;
    logic [ADDR_W-1:0] diff;
    int                n_ign;

    always_comb begin
        n_ign = ignored_bits(mask_code);
        for (int i = 0; i < ADDR_W; i++) begin
            care[i] = (i >= n_ign);
        end
        diff = (bus_addr ^ brk_addr) & care;
        hit  = strobe
            && (diff == '0)
            && kind_accepts(cyc_sel, kind)
            && master_accepts(any_master, from_dtc);
    end

endmodule

// File: rtl/abrk_channel.sv
module abrk_channel
    import abrk_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CH     = 0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [REG_AW-1:0]            reg_addr,
    input  logic [7:0]                   reg_wdata,
    input  logic                         bus_valid,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  bus_kind_e                    bus_kind,
    input  logic                         bus_dtc,
    output logic [((ADDR_W+7)/8)*8-1:0]  addr_store,
    output brk_ctrl_t                    ctrl_q,
    output logic                         hit
);

    localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
    localparam logic [REG_AW-1:0] CTRL_OFF = CTRL_BASE + REG_AW'(CH);
    localparam logic [REG_AW-1:0] ADDR_OFF = REG_AW'(CH * ADDR_STRIDE);

    logic       flag_q;
    logic       armed_q;
    logic       any_master_q;
    logic [2:0] mask_code_q;
    cyc_sel_e   cyc_sel_q;
    logic       irq_en_q;

    logic wr_ctrl;
    logic rd_ctrl;
    logic clear_ok;

    assign wr_ctrl  = reg_wr && (reg_addr == CTRL_OFF);
    assign rd_ctrl  = reg_rd && (reg_addr == CTRL_OFF);
    assign clear_ok = wr_ctrl && armed_q && !reg_wdata[7];

    // Break address bytes, one register per byte lane.
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_byte
        localparam logic [REG_AW-1:0] BYTE_OFF = ADDR_OFF + REG_AW'(k);
        always_ff @(posedge clk) begin
            if (rst) begin
                addr_store[k*8 +: 8] <= '0;
            end else if (reg_wr && (reg_addr == BYTE_OFF)) begin
                addr_store[k*8 +: 8] <= reg_wdata;
            end
        end
    end

    // Writable control fields.
    always_ff @(posedge clk) begin
        if (rst) begin
            any_master_q <= 1'b0;
            mask_code_q  <= 3'd0;
            cyc_sel_q    <= SEL_FETCH;
            irq_en_q     <= 1'b0;
        end else if (wr_ctrl) begin
            any_master_q <= reg_wdata[6];
            mask_code_q  <= reg_wdata[5:3];
            cyc_sel_q    <= cyc_sel_e'(reg_wdata[2:1]);
            irq_en_q     <= reg_wdata[0];
        end
    end

    // Sticky flag with read-before-clear permission; a new match wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (hit) begin
                flag_q <= 1'b1;
            end else if (clear_ok) begin
                flag_q <= 1'b0;
            end
            if (rd_ctrl && flag_q) begin
                armed_q <= 1'b1;
            end else if (wr_ctrl) begin
                armed_q <= 1'b0;
            end
        end
    end

    always_comb begin
        ctrl_q.hit_flag   = flag_q;
        ctrl_q.any_master = any_master_q;
        ctrl_q.mask_code  = mask_code_q;
        ctrl_q.cyc_sel    = cyc_sel_q;
        ctrl_q.irq_en     = irq_en_q;
    end

    abrk_match #(.ADDR_W(ADDR_W)) u_match (
        .strobe     (bus_valid),
        .bus_addr   (bus_addr),
        .kind       (bus_kind),
        .from_dtc   (bus_dtc),
        .brk_addr   (addr_store[ADDR_W-1:0]),
        .mask_code  (mask_code_q),
        .cyc_sel    (cyc_sel_q),
        .any_master (any_master_q),
        .hit        (hit)
    );

endmodule

// File: rtl/addr_break_unit.sv
module addr_break_unit
    import abrk_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_kind,
    input  logic              bus_dtc,
    output logic              brk_irq
);

    localparam int ADDR_BYTES = (ADDR_W + 7) / 8;

    logic [ADDR_BYTES*8-1:0] addr_store [NUM_CH];
    brk_ctrl_t               ctrl_q     [NUM_CH];
    logic [NUM_CH-1:0]       hit_v;
    logic [NUM_CH-1:0]       flag_v;
    logic [NUM_CH-1:0]       ie_v;
    bus_kind_e               kind_e;

    assign kind_e = bus_kind_e'(bus_kind);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        abrk_channel #(.ADDR_W(ADDR_W), .CH(c)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .reg_wr     (reg_wr),
            .reg_rd     (reg_rd),
            .reg_addr   (reg_addr),
            .reg_wdata  (reg_wdata),
            .bus_valid  (bus_valid),
            .bus_addr   (bus_addr),
            .bus_kind   (kind_e),
            .bus_dtc    (bus_dtc),
            .addr_store (addr_store[c]),
            .ctrl_q     (ctrl_q[c]),
            .hit        (hit_v[c])
        );
        assign flag_v[c] = ctrl_q[c].hit_flag;
        assign ie_v[c]   = ctrl_q[c].irq_en;
    end

    // Read path: address bytes per channel stride, control bytes at CTRL_BASE.
    always_comb begin
        reg_rdata = 8'h00;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int k = 0; k < ADDR_BYTES; k++) begin
                if (reg_addr == REG_AW'(c * ADDR_STRIDE + k)) begin
                    reg_rdata = addr_store[c][k*8 +: 8];
                end
            end
            if (reg_addr == CTRL_BASE + REG_AW'(c)) begin
                reg_rdata = ctrl_q[c];
            end
        end
    end

    assign brk_irq = |(flag_v & ie_v);

endmodule

// File: rtl/abrk_checker.sv
module abrk_checker
    import abrk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [3:0]        reg_addr,
    input logic              wr_bit7,
    input logic              bus_valid,
    input logic [1:0]        bus_kind,
    input logic [NUM_CH-1:0] hit_v,
    input logic [NUM_CH-1:0] flag_v,
    input logic              brk_irq
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam logic [3:0] COFF = CTRL_BASE + 4'(c);

        p_hit_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
            hit_v[c] |=> flag_v[c]);

        p_no_hit_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
            !bus_valid |-> !hit_v[c]);

        p_no_software_set_r3: assert property (@(posedge clk) disable iff (rst)
            (!flag_v[c] && !hit_v[c]) |=> !flag_v[c]);

        p_clear_needs_write0_r8: assert property (@(posedge clk) disable iff (rst)
            (flag_v[c] && !(reg_wr && reg_addr == COFF && !wr_bit7)) |=> flag_v[c]);

        p_idle_kind_never_hits_r5: assert property (@(posedge clk) disable iff (rst)
            (bus_kind == 2'b11) |-> !hit_v[c]);
    end

    p_quiet_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (flag_v == '0) |-> !brk_irq);

endmodule

bind addr_break_unit abrk_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wr_bit7   (reg_wdata[7]),
    .bus_valid (bus_valid),
    .bus_kind  (bus_kind),
    .hit_v     (hit_v),
    .flag_v    (flag_v),
    .brk_irq   (brk_irq)
);

// File: tb/addr_break_unit_tb.sv
`timescale 1ns/1ps
module addr_break_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_rd;
    logic [3:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        bus_valid;
    logic [23:0] bus_addr;
    logic [1:0]  bus_kind;
    logic        bus_dtc;
    logic        brk_irq;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    addr_break_unit u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_kind(bus_kind),
        .bus_dtc(bus_dtc), .brk_irq(brk_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic bus(input logic [23:0] a, input logic [1:0] k, input logic m,
                       input logic v, output logic irq_s);
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_kind = k; bus_dtc = m;
        @(negedge clk);
        bus_valid = 1'b0;
        #1 irq_s = brk_irq;
    endtask

    task automatic set_addr(input int ch, input logic [23:0] a);
        for (int k = 0; k < 3; k++) wr(4'(ch * 4 + k), a[k*8 +: 8]);
    endtask

    // Valid clear sequence: qualifying read, then write 0 to the flag bit.
    task automatic clr(input int ch, input logic [6:0] cfg);
        logic [7:0] d;
        rd(4'(8 + ch), d);
        wr(4'(8 + ch), {1'b0, cfg});
    endtask

    function automatic int n_ign(input int code);
        return (code <= 4) ? code : (code - 4) * 4 + 4;
    endfunction

    function automatic logic kind_ok(input int sel, input int kind);
        if (sel == 3) return (kind == 1) || (kind == 2);
        return sel == kind;
    endfunction

    localparam logic [23:0] BASE_A = 24'h5A3C96;
    localparam logic [23:0] BASE_B = 24'hC31E7B;

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       irq_s;
        logic [6:0] cfg;

        rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        bus_valid = 0; bus_addr = 0; bus_kind = 0; bus_dtc = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every offset and the irq
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check("R1 reset read", d, 0);
        end
        check("R1 reset irq", brk_irq, 0);

        // R2: address byte readback, unmapped offset stays 0
        set_addr(0, BASE_A);
        set_addr(1, BASE_B);
        for (int k = 0; k < 3; k++) begin
            rd(4'(k), d);     check("R2 chan0 byte", d, BASE_A[k*8 +: 8]);
            rd(4'(4 + k), d); check("R2 chan1 byte", d, BASE_B[k*8 +: 8]);
        end
        wr(4'hC, 8'hFF);
        rd(4'hC, d); check("R2 unmapped", d, 0);

        // R3: bits 6:0 writable, writing 1 to bit 7 does not set the flag
        wr(4'h9, 8'hFF);
        rd(4'h9, d); check("R3 ctrl readback", d, 8'h7F);
        wr(4'h9, 8'h00);
        rd(4'h9, d); check("R3 ctrl zero", d, 8'h00);

        // Channel 1 fetch-only at a far address: must stay quiet (R12)
        wr(4'h9, {1'b0, 1'b0, 3'd0, 2'b00, 1'b1});

        // R4/R7/R10: mask sweep on channel 0, read-only, CPU, irq enabled
        for (int code = 0; code < 8; code++) begin
            cfg = {1'b0, 3'(code), 2'b01, 1'b1};
            wr(4'h8, {1'b0, cfg});
            for (int b = -1; b < 24; b++) begin
                logic [23:0] a;
                logic        exp;
                a   = (b < 0) ? BASE_A : (BASE_A ^ (24'd1 << b));
                exp = (b < 0) || (b < n_ign(code));
                bus(a, 2'b01, 1'b0, 1'b1, irq_s);
                check("R10 irq after mask vector", irq_s, exp);
                rd(4'h8, d);
                check("R4 mask flag", d, {exp, cfg});
                if (d[7]) wr(4'h8, {1'b0, cfg});
            end
        end

        // R5/R6: cycle select x kind x master select x bus master
        for (int s = 0; s < 4; s++)
            for (int ms = 0; ms < 2; ms++)
                for (int k = 0; k < 4; k++)
                    for (int m = 0; m < 2; m++) begin
                        logic exp;
                        cfg = {1'(ms), 3'd0, 2'(s), 1'b1};
                        wr(4'h8, {1'b0, cfg});
                        exp = kind_ok(s, k) && ((m == 0) || (ms == 1));
                        bus(BASE_A, 2'(k), 1'(m), 1'b1, irq_s);
                        rd(4'h8, d);
                        check("R5 R6 kind/master flag", d[7], exp);
                        if (d[7]) wr(4'h8, {1'b0, cfg});
                    end

        // R12: channel 1 never matched during all the above
        rd(4'h9, d); check("R12 chan1 untouched", d[7], 0);

        // R7: valid low never matches; flag sticks across idle cycles
        cfg = {1'b0, 3'd0, 2'b10, 1'b1};
        wr(4'h8, {1'b0, cfg});
        bus(BASE_A, 2'b10, 1'b0, 1'b0, irq_s);
        check("R7 no strobe no irq", irq_s, 0);
        bus(BASE_A, 2'b10, 1'b0, 1'b1, irq_s);
        repeat (5) @(negedge clk);
        #1 check("R7 sticky irq", brk_irq, 1);

        // R8: write 0 without a qualifying read leaves the flag
        wr(4'h8, {1'b0, cfg});
        #1 check("R8 unread clear ignored", brk_irq, 1);
        rd(4'h8, d); check("R8 flag still set", d[7], 1);
        wr(4'h8, {1'b0, cfg});
        rd(4'h8, d); check("R8 clear after read", d[7], 0);

        // R9: a write with bit 7 = 1 disarms without clearing
        bus(BASE_A, 2'b10, 1'b0, 1'b1, irq_s);
        rd(4'h8, d);
        wr(4'h8, {1'b1, cfg});
        wr(4'h8, {1'b0, cfg});
        rd(4'h8, d); check("R9 disarmed write ignored", d[7], 1);
        clr(0, cfg);
        rd(4'h8, d); check("R9 clear after re-read", d[7], 0);

        // R10: enable off blocks irq; turning it on raises it
        cfg = {1'b0, 3'd0, 2'b10, 1'b0};
        wr(4'h8, {1'b0, cfg});
        bus(BASE_A, 2'b10, 1'b0, 1'b1, irq_s);
        check("R10 disabled irq", irq_s, 0);
        rd(4'h8, d); check("R10 flag with irq off", d[7], 1);
        wr(4'h8, {1'b1, cfg[6:1], 1'b1});
        #1 check("R10 enable raises irq", brk_irq, 1);
        cfg = {1'b0, 3'd0, 2'b10, 1'b1};
        clr(0, cfg);
        #1 check("R10 irq drops after clear", brk_irq, 0);

        // R11: match and valid clear in the same cycle -> flag stays
        bus(BASE_A, 2'b10, 1'b0, 1'b1, irq_s);
        rd(4'h8, d);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = BASE_A; bus_kind = 2'b10; bus_dtc = 1'b0;
        reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = {1'b0, cfg};
        @(negedge clk);
        bus_valid = 1'b0; reg_wr = 1'b0;
        rd(4'h8, d); check("R11 set beats clear", d[7], 1);
        clr(0, cfg);

        // R12: channel 1 match leaves channel 0 flag clear, irq is the OR
        bus(BASE_B, 2'b00, 1'b0, 1'b1, irq_s);
        check("R12 chan1 irq", irq_s, 1);
        rd(4'h8, d); check("R12 chan0 flag clear", d[7], 0);
        rd(4'h9, d); check("R12 chan1 flag set", d[7], 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule